// File: doc/BRIEF.md
# Blank-Run Sync Regenerator

Some video sources deliver pixels framed only by a data-valid strobe (DE) and carry no line or frame sync at all. This block rebuilds both syncs from the blanking alone. A counter runs over consecutive pixel clocks in which DE is low. When the run first reaches a programmable line threshold, the block emits a one-clock line sync. When the same run first reaches a larger programmable frame threshold, it emits a one-clock frame sync. Downstream framing logic can then order lines and frames as if explicit syncs had arrived.

The two thresholds come from configuration inputs. A legal setup has a line threshold of at least 2 that is strictly below the frame threshold. Any other setup raises an error flag, and the block emits no pulses while that flag is set. The block does not measure any timing. It only counts blank runs and produces pulses.

Top module: `gap_sync_regen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hsync_out`, `vsync_out` and `cfg_err` are all 0.
- R2: With a legal setup, `hsync_out` is high for exactly one clock in the cycle that follows the clock edge sampling the `hgap_len`-th consecutive DE=0 pixel.
- R3: A DE=1 pixel clears the blank-run count, so a run shorter than `hgap_len` produces no pulse even when several such runs come back to back.
- R4: With a legal setup, `vsync_out` is high for exactly one clock in the cycle that follows the edge sampling the `vgap_len`-th consecutive DE=0 pixel. The same run will already have produced its line pulse.
- R5: Each blank run produces at most one line pulse and at most one frame pulse, however long the run lasts.
- R6: The blank-run count saturates at its all-ones value (2^CNT_W-1) and never wraps. A run longer than that fires no second pulse, and a threshold equal to the all-ones value still fires once.
- R7: `cfg_err` is 1, one clock after the setup is applied, when `hgap_len` <= 1 or `hgap_len` >= `vgap_len`, and 0 otherwise. While it is 1, neither pulse is emitted.
- R8: `hsync_out` and `vsync_out` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_in | input | 1 | Data-enable of the incoming pixel (1 = active pixel) |
| hgap_len | input | CNT_W | Blank-run length that triggers a line sync |
| vgap_len | input | CNT_W | Blank-run length that triggers a frame sync |
| hsync_out | output | 1 | Regenerated line sync, one-clock pulse |
| vsync_out | output | 1 | Regenerated frame sync, one-clock pulse |
| cfg_err | output | 1 | Threshold setup is illegal; pulses suppressed |

## Verification
The hardest case to reach from the ports is the saturated counter. Here a blank run outlasts the counter range, and the frame threshold sits exactly on the all-ones value, where the count stops moving and could match again on every cycle. The bench builds the design with a narrow 6-bit counter. It can then hold DE low for 70 and 100 pixels and record the position of every pulse. This shows that the all-ones threshold fires exactly once and that nothing fires after saturation. Interrupted runs and mid-run resets are driven separately, so that the count's clear paths are observed at the outputs.

// File: rtl/gapsync_pkg.sv
package gapsync_pkg;

  // Channel order: line sync uses the smaller threshold, frame sync the larger one.
  typedef enum int unsigned {
    CH_LINE  = 0,
    CH_FRAME = 1
  } sync_ch_e;

  localparam int unsigned NUM_CH = 2;

  // Legal setup: line threshold at least 2 and strictly below the frame threshold.
  function automatic logic thresholds_legal(input logic [31:0] line_thr,
                                            input logic [31:0] frame_thr);
    return (line_thr > 32'd1) && (line_thr < frame_thr);
  endfunction

endpackage

// File: rtl/gsr_gap_counter.sv
module gsr_gap_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Saturating increment: parks at all-ones.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  always_comb begin
    if (de_in) cnt_nxt = '0;
    else       cnt_nxt = sat_inc(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R3: an active pixel empties the run count
  assert_clear_on_de_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de_in |=> (cnt_q == '0));

  // R6: a saturated count holds instead of wrapping
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_in && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R6: a blank pixel below saturation advances the count by one
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_in && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/gsr_pulse_gen.sv
module gsr_pulse_gen #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             de_in,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] thresh,
  output logic             pulse_o
);

  // Fires only on the edge where the count first lands on the threshold.
  function automatic logic first_hit(input logic [CNT_W-1:0] cur,
                                     input logic [CNT_W-1:0] nxt,
                                     input logic [CNT_W-1:0] thr);
    return (nxt == thr) && (cur != thr);
  endfunction

  logic hit_now;
  assign hit_now = enable && !de_in && first_hit(cnt_q, cnt_nxt, thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= hit_now;
  end

  // R2/R4: a pulse lasts one clock
  assert_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R5: a pulse only follows a blank pixel that brought the count to the threshold
  assert_on_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> (cnt_q == thresh));

endmodule

// File: rtl/gsr_cfg_check.sv
module gsr_cfg_check #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hgap_len,
  input  logic [CNT_W-1:0] vgap_len,
  output logic             cfg_ok,
  output logic             cfg_err_q
);

  import gapsync_pkg::*;

  assign cfg_ok = thresholds_legal(32'(hgap_len), 32'(vgap_len));

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err_q <= 1'b0;
    else        cfg_err_q <= !cfg_ok;
  end

  // R7: the flag tracks the previous cycle's setup
  assert_err_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err_q) |-> ($past(hgap_len) <= 1 || $past(hgap_len) >= $past(vgap_len)));

endmodule

// File: rtl/gap_sync_regen.sv
module gap_sync_regen #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_in,
  input  logic [CNT_W-1:0] hgap_len,
  input  logic [CNT_W-1:0] vgap_len,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             cfg_err
);

  import gapsync_pkg::*;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_cnt_nxt;
  logic             cfg_ok;
  logic [CNT_W-1:0] thr [NUM_CH];
  logic [NUM_CH-1:0] pulses;

  assign thr[CH_LINE]  = hgap_len;
  assign thr[CH_FRAME] = vgap_len;

  gsr_gap_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .de_in   (de_in),
    .cnt_q   (run_cnt),
    .cnt_nxt (run_cnt_nxt)
  );

  gsr_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .hgap_len  (hgap_len),
    .vgap_len  (vgap_len),
    .cfg_ok    (cfg_ok),
    .cfg_err_q (cfg_err)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    gsr_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (cfg_ok),
      .de_in   (de_in),
      .cnt_q   (run_cnt),
      .cnt_nxt (run_cnt_nxt),
      .thresh  (thr[ch]),
      .pulse_o (pulses[ch])
    );
  end

  assign hsync_out = pulses[CH_LINE];
  assign vsync_out = pulses[CH_FRAME];

  // R7: pulses are withheld under an illegal setup
  assert_err_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!hsync_out && !vsync_out));

  // R8: the two syncs never coincide
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hsync_out, vsync_out}));

  // R1: outputs leave reset low
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!hsync_out && !vsync_out && !cfg_err));

endmodule

// File: tb/gap_sync_regen_bench.sv
module gap_sync_regen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int NV = 8;
  // {hgap, vgap, run length, expected line position, expected frame position}; 0 = no pulse
  localparam int VEC [NV][5] = '{
    '{ 4, 10,   3,  0,  0},
    '{ 4, 10,   4,  4,  0},
    '{ 4, 10,  12,  4, 10},
    '{ 2,  3,   5,  2,  3},
    '{ 5,  5,   8,  0,  0},
    '{ 1,  8,   9,  0,  0},
    '{10, 63,  70, 10, 63},
    '{ 3, 20, 100,  3, 20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de_in = 1'b1;
  logic [W-1:0] hgap_len = W'(4);
  logic [W-1:0] vgap_len = W'(10);
  logic hsync_out, vsync_out, cfg_err;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gap_sync_regen #(.CNT_W(W)) u_gap_sync_regen (
    .clk(clk), .rst_n(rst_n), .de_in(de_in),
    .hgap_len(hgap_len), .vgap_len(vgap_len),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp_v, input string what);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // Drive a blank run and report where pulses appeared (1-based blank index).
  task automatic run_gap(input int len, output int hpos, output int vpos,
                         output int hcnt, output int vcnt, output int both);
    hpos = 0; vpos = 0; hcnt = 0; vcnt = 0; both = 0;
    @(negedge clk); de_in = 1'b0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (hsync_out) begin hcnt++; if (hpos == 0) hpos = k; end
      if (vsync_out) begin vcnt++; if (vpos == 0) vpos = k; end
      if (hsync_out && vsync_out) both++;
    end
    de_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (hsync_out) hcnt++;
      if (vsync_out) vcnt++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hp, vp, hc, vc, bo;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", {29'd0, hsync_out, vsync_out, cfg_err}, 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'd0, hsync_out, vsync_out, cfg_err}, 0, "outputs after reset");

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      int exp_err, exp_h, exp_v;
      @(negedge clk);
      hgap_len = W'(VEC[i][0]);
      vgap_len = W'(VEC[i][1]);
      de_in = 1'b1;
      repeat (2) @(negedge clk);
      exp_err = (VEC[i][0] < 2 || VEC[i][0] >= VEC[i][1]) ? 1 : 0;
      check("R7", int'(cfg_err), exp_err, $sformatf("cfg_err vec %0d", i));
      run_gap(VEC[i][2], hp, vp, hc, vc, bo);
      exp_h = (VEC[i][3] != 0) ? 1 : 0;
      exp_v = (VEC[i][4] != 0) ? 1 : 0;
      check("R2", hp, VEC[i][3], $sformatf("line pulse position vec %0d", i));
      check("R4", vp, VEC[i][4], $sformatf("frame pulse position vec %0d", i));
      check(VEC[i][2] > 63 ? "R6" : "R5", hc, exp_h, $sformatf("line pulse count vec %0d", i));
      check(VEC[i][2] > 63 ? "R6" : "R5", vc, exp_v, $sformatf("frame pulse count vec %0d", i));
      check("R8", bo, 0, $sformatf("coincident pulses vec %0d", i));
    end

    // R3: interrupted short runs never reach the threshold
    @(negedge clk); hgap_len = W'(4); vgap_len = W'(10);
    repeat (2) @(negedge clk);
    hc = 0;
    for (int r = 0; r < 4; r++) begin
      de_in = 1'b0;
      repeat (3) begin @(negedge clk); if (hsync_out) hc++; end
      de_in = 1'b1;
      @(negedge clk); if (hsync_out) hc++;
    end
    check("R3", hc, 0, "pulses from 3-pixel runs split by DE");
    run_gap(4, hp, vp, hc, vc, bo);
    check("R3", hp, 4, "line pulse after clear and full run");

    // R1: reset in the middle of a run clears the count
    @(negedge clk); de_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hc = 0; hp = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (hsync_out) begin hc++; if (hp == 0) hp = k; end
    end
    de_in = 1'b1;
    check("R1", hp, 4, "line pulse position after mid-run reset");

    // R7: recovery from an illegal setup re-enables pulses
    @(negedge clk); hgap_len = W'(9); vgap_len = W'(9);
    repeat (2) @(negedge clk);
    check("R7", int'(cfg_err), 1, "equal thresholds flagged");
    @(negedge clk); vgap_len = W'(12);
    @(negedge clk);
    check("R7", int'(cfg_err), 0, "flag clears one clock after legal setup");
    run_gap(13, hp, vp, hc, vc, bo);
    check("R7", hp, 9, "line pulse after recovery");
    check("R4", vp, 12, "frame pulse after recovery");

    finish_run();
  end

endmodule